// File: doc/BRIEF.md
# Pipelined Complex Multiply-Accumulate Unit

This unit multiplies two signed 18-bit complex operands, A and B, and produces a 58-bit real result and a 58-bit imaginary result. Two lanes share one operand pipeline. The real lane forms Ar*Br - Ai*Bi and the imaginary lane forms Ar*Bi + Ai*Br. Either operand can be conjugated before the multiply; conjugation flips the sign of that operand's imaginary part.

Each lane has its own two-bit mode. The mode picks what is added to the product: nothing, the lane's own previous result (accumulate), a 58-bit C value, or a 58-bit cascade input from a neighbouring unit. Parameters set the pipeline shape:

- The A and B operand chains are 0, 1 or 2 registers deep.
- The C, multiplier, result, conjugate and mode registers are each optional.
- The A and B operands can be taken from the cascade inputs instead of the direct ports.
- The A and B cascade outputs are tapped at a chosen depth of their operand chains.

Top module: `cmac_unit`

## Requirements
- R1: With both modes at 0 (nothing added), after the pipeline has settled pRe equals Ar*Br - Ai*Bi and pIm equals Ar*Bi + Ai*Br. The operands are signed 18-bit values and each product is sign-extended to 58 bits.
- R2: conjA high replaces Ai by -Ai, and conjB high replaces Bi by -Bi, before the multiply. The two controls act independently.
- R3: A lane's mode selects its addend: 0 adds nothing, 1 adds that lane's own registered result (accumulate), 2 adds the C input of that lane, 3 adds the pcin input of that lane.
- R4: A change on the A or B ports reaches pRe/pIm exactly A_DEPTH + M_REG + P_REG rising edges later. With the defaults this is 4 edges. The result does not change on any earlier edge.
- R5: acoutRe/acoutIm show the A operand after ACOUT_TAP registers of the A chain. bcoutRe/bcoutIm show the B operand after BCOUT_TAP registers of the B chain. A tap deeper than its chain is refused at elaboration.
- R6: With A_IN_CASCADE set, the A operand is taken from acinRe/acinIm instead of aRe/aIm, and likewise B from bcin with B_IN_CASCADE.
- R7: Each register stage holds its value while its clock enable is low. ceA1/ceA2 and ceB1/ceB2 act per stage, and ceC, ceM, ceP, ceCtrl and ceConj each act on their own group.
- R8: Each synchronous active-high reset clears only its own group. The groups are A chain, B chain, C, multiplier, result, mode and conjugate.
- R9: pcoutRe/pcoutIm always equal pRe/pIm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aRe | input | 18 | A real part |
| aIm | input | 18 | A imaginary part |
| bRe | input | 18 | B real part |
| bIm | input | 18 | B imaginary part |
| acinRe | input | 18 | A real from a neighbour's cascade |
| acinIm | input | 18 | A imaginary from a neighbour's cascade |
| bcinRe | input | 18 | B real from a neighbour's cascade |
| bcinIm | input | 18 | B imaginary from a neighbour's cascade |
| cRe | input | 58 | Real addend |
| cIm | input | 58 | Imaginary addend |
| pcinRe | input | 58 | Real result cascade in |
| pcinIm | input | 58 | Imaginary result cascade in |
| conjA | input | 1 | Conjugate A |
| conjB | input | 1 | Conjugate B |
| modeRe | input | 2 | Real lane addend select |
| modeIm | input | 2 | Imaginary lane addend select |
| ceA1 | input | 1 | Enable, first A stage |
| ceA2 | input | 1 | Enable, second A stage |
| ceB1 | input | 1 | Enable, first B stage |
| ceB2 | input | 1 | Enable, second B stage |
| ceC | input | 1 | Enable, C registers |
| ceM | input | 1 | Enable, multiplier registers |
| ceP | input | 1 | Enable, result registers |
| ceCtrl | input | 1 | Enable, mode registers |
| ceConj | input | 1 | Enable, conjugate registers |
| rstA | input | 1 | Reset, A chain |
| rstB | input | 1 | Reset, B chain |
| rstC | input | 1 | Reset, C registers |
| rstM | input | 1 | Reset, multiplier registers |
| rstP | input | 1 | Reset, result registers |
| rstCtrl | input | 1 | Reset, mode registers |
| rstConj | input | 1 | Reset, conjugate registers |
| pRe | output | 58 | Real result |
| pIm | output | 58 | Imaginary result |
| pcoutRe | output | 58 | Real result cascade out |
| pcoutIm | output | 58 | Imaginary result cascade out |
| acoutRe | output | 18 | A real cascade out |
| acoutIm | output | 18 | A imaginary cascade out |
| bcoutRe | output | 18 | B real cascade out |
| bcoutIm | output | 18 | B imaginary cascade out |

## Verification
The bench builds two instances. The first is fully registered, with 2-deep A and B chains, the A tap equal to the chain depth and the B tap at 1. This brings the latency count, the per-stage enables, the group resets and accumulation within reach. The second is almost combinational and takes its A operand from the first unit's A cascade output, which exercises the cascade path end to end. The sweep covers every combination of six corner values for each of the four operand parts, including the most negative value, under all four conjugate settings, and compares the results with arithmetic done in the bench.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic [1:0] {
    ADD_NONE = 2'd0,
    ADD_SELF = 2'd1,
    ADD_C    = 2'd2,
    ADD_CASC = 2'd3
  } addSel_e;

  typedef struct packed {
    logic    conjA;
    logic    conjB;
    addSel_e selRe;
    addSel_e selIm;
  } ctrlStrobe_t;
endpackage

// File: rtl/cmac_oppipe.sv
module cmac_oppipe #(
  parameter int W     = 36,
  parameter int DEPTH = 2,
  parameter int TAP   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   ce,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] tap
);
  logic [W-1:0] stage [0:DEPTH];

  if (DEPTH > 2) begin : gBadDepth
    $error("operand chain deeper than two stages");
  end
  if (TAP > DEPTH) begin : gBadTap
    $error("cascade tap deeper than operand chain");
  end

  assign stage[0] = din;

  for (genvar k = 1; k <= DEPTH; k++) begin : gStage
    always_ff @(posedge clk) begin
      if (rst)            stage[k] <= '0;
      else if (ce[k-1])   stage[k] <= stage[k-1];
    end

    // R7: a stage with its enable low keeps its content
    assert_stage_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !ce[k-1] |=> $stable(stage[k]));
    // R8: the chain reset empties every stage
    assert_stage_clear_R8: assert property (@(posedge clk)
      rst |=> (stage[k] == '0));
  end

  assign dout = stage[DEPTH];
  assign tap  = stage[TAP];
endmodule

// File: rtl/cmac_ctrl.sv
module cmac_ctrl
  import cmac_pkg::*;
#(
  parameter bit CONJ_REG = 1,
  parameter bit CTRL_REG = 1
) (
  input  logic        clk,
  input  logic        conjA,
  input  logic        conjB,
  input  logic [1:0]  modeRe,
  input  logic [1:0]  modeIm,
  input  logic        ceConj,
  input  logic        rstConj,
  input  logic        ceCtrl,
  input  logic        rstCtrl,
  output ctrlStrobe_t strobe
);
  logic [1:0] conjQ;
  logic [3:0] modeQ;

  if (CONJ_REG) begin : gConjReg
    always_ff @(posedge clk) begin
      if (rstConj)     conjQ <= '0;
      else if (ceConj) conjQ <= {conjA, conjB};
    end
    // R8: conjugate reset clears both conjugate flags
    assert_conj_clear_R8: assert property (@(posedge clk)
      rstConj |=> (conjQ == 2'b00));
  end else begin : gConjWire
    assign conjQ = {conjA, conjB};
  end

  if (CTRL_REG) begin : gCtrlReg
    always_ff @(posedge clk) begin
      if (rstCtrl)     modeQ <= '0;
      else if (ceCtrl) modeQ <= {modeRe, modeIm};
    end
    // R7: mode register holds while disabled
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rstCtrl)
      !ceCtrl |=> $stable(modeQ));
  end else begin : gCtrlWire
    assign modeQ = {modeRe, modeIm};
  end

  always_comb begin
    strobe.conjA = conjQ[1];
    strobe.conjB = conjQ[0];
    strobe.selRe = addSel_e'(modeQ[3:2]);
    strobe.selIm = addSel_e'(modeQ[1:0]);
  end
endmodule

// File: rtl/cmac_datapath.sv
module cmac_datapath
  import cmac_pkg::*;
#(
  parameter int AW           = 18,
  parameter int PW           = 58,
  parameter int A_DEPTH      = 2,
  parameter int B_DEPTH      = 2,
  parameter int ACOUT_TAP    = 2,
  parameter int BCOUT_TAP    = 1,
  parameter bit A_IN_CASCADE = 0,
  parameter bit B_IN_CASCADE = 0,
  parameter bit C_REG        = 1,
  parameter bit M_REG        = 1,
  parameter bit P_REG        = 1
) (
  input  logic            clk,
  input  ctrlStrobe_t     strobe,
  input  logic [2*AW-1:0] aIn,
  input  logic [2*AW-1:0] acin,
  input  logic [2*AW-1:0] bIn,
  input  logic [2*AW-1:0] bcin,
  input  logic [PW-1:0]   cRe,
  input  logic [PW-1:0]   cIm,
  input  logic [PW-1:0]   pcinRe,
  input  logic [PW-1:0]   pcinIm,
  input  logic [1:0]      ceA,
  input  logic [1:0]      ceB,
  input  logic            ceC,
  input  logic            ceM,
  input  logic            ceP,
  input  logic            rstA,
  input  logic            rstB,
  input  logic            rstC,
  input  logic            rstM,
  input  logic            rstP,
  output logic [PW-1:0]   pRe,
  output logic [PW-1:0]   pIm,
  output logic [2*AW-1:0] acout,
  output logic [2*AW-1:0] bcout
);
  localparam int XW = AW + 1;
  localparam int MW = 2 * XW + 1;

  logic [2*AW-1:0] aSrc, bSrc, aOp, bOp;
  assign aSrc = A_IN_CASCADE ? acin : aIn;
  assign bSrc = B_IN_CASCADE ? bcin : bIn;

  cmac_oppipe #(.W(2*AW), .DEPTH(A_DEPTH), .TAP(ACOUT_TAP)) uPipeA (
    .clk(clk), .rst(rstA), .ce(ceA), .din(aSrc), .dout(aOp), .tap(acout));
  cmac_oppipe #(.W(2*AW), .DEPTH(B_DEPTH), .TAP(BCOUT_TAP)) uPipeB (
    .clk(clk), .rst(rstB), .ce(ceB), .din(bSrc), .dout(bOp), .tap(bcout));

  // widen by one bit so negating the most negative value is exact
  logic signed [XW-1:0] ar, ai, br, bi;
  always_comb begin
    ar = XW'($signed(aOp[2*AW-1:AW]));
    ai = XW'($signed(aOp[AW-1:0]));
    br = XW'($signed(bOp[2*AW-1:AW]));
    bi = XW'($signed(bOp[AW-1:0]));
    if (strobe.conjA) ai = -ai;
    if (strobe.conjB) bi = -bi;
  end

  logic signed [MW-1:0] mulRe, mulIm;
  assign mulRe = MW'(ar * br) - MW'(ai * bi);
  assign mulIm = MW'(ar * bi) + MW'(ai * br);

  logic [PW-1:0] prodRe, prodIm, mRe, mIm;
  assign prodRe = {{(PW-MW){mulRe[MW-1]}}, mulRe};
  assign prodIm = {{(PW-MW){mulIm[MW-1]}}, mulIm};

  if (M_REG) begin : gMReg
    always_ff @(posedge clk) begin
      if (rstM)     begin mRe <= '0; mIm <= '0; end
      else if (ceM) begin mRe <= prodRe; mIm <= prodIm; end
    end
    // R8: multiplier reset clears both lanes
    assert_m_clear_R8: assert property (@(posedge clk)
      rstM |=> (mRe == '0 && mIm == '0));
  end else begin : gMWire
    assign mRe = prodRe;
    assign mIm = prodIm;
  end

  logic [PW-1:0] cReQ, cImQ;
  if (C_REG) begin : gCReg
    always_ff @(posedge clk) begin
      if (rstC)     begin cReQ <= '0; cImQ <= '0; end
      else if (ceC) begin cReQ <= cRe; cImQ <= cIm; end
    end
    // R8: C reset clears both lanes
    assert_c_clear_R8: assert property (@(posedge clk)
      rstC |=> (cReQ == '0 && cImQ == '0));
  end else begin : gCWire
    assign cReQ = cRe;
    assign cImQ = cIm;
  end

  logic [PW-1:0] pReQ, pImQ, addRe, addIm;

  function automatic logic [PW-1:0] pickAddend(addSel_e sel, logic [PW-1:0] self,
                                               logic [PW-1:0] cv, logic [PW-1:0] casc);
    case (sel)
      ADD_SELF: return P_REG ? self : '0;
      ADD_C:    return cv;
      ADD_CASC: return casc;
      default:  return '0;
    endcase
  endfunction

  assign addRe = pickAddend(strobe.selRe, pReQ, cReQ, pcinRe);
  assign addIm = pickAddend(strobe.selIm, pImQ, cImQ, pcinIm);

  if (P_REG) begin : gPReg
    always_ff @(posedge clk) begin
      if (rstP)     begin pReQ <= '0; pImQ <= '0; end
      else if (ceP) begin pReQ <= mRe + addRe; pImQ <= mIm + addIm; end
    end
    // R8: result reset clears both lanes
    assert_p_clear_R8: assert property (@(posedge clk)
      rstP |=> (pReQ == '0 && pImQ == '0));
    // R7: result holds while its enable is low
    assert_p_hold_R7: assert property (@(posedge clk) disable iff (rstP)
      !ceP |=> ($stable(pReQ) && $stable(pImQ)));
  end else begin : gPWire
    assign pReQ = mRe + addRe;
    assign pImQ = mIm + addIm;
  end

  assign pRe = pReQ;
  assign pIm = pImQ;
endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
  import cmac_pkg::*;
#(
  parameter int AW           = 18,
  parameter int PW           = 58,
  parameter int A_DEPTH      = 2,
  parameter int B_DEPTH      = 2,
  parameter int ACOUT_TAP    = 2,
  parameter int BCOUT_TAP    = 1,
  parameter bit A_IN_CASCADE = 0,
  parameter bit B_IN_CASCADE = 0,
  parameter bit C_REG        = 1,
  parameter bit M_REG        = 1,
  parameter bit P_REG        = 1,
  parameter bit CONJ_REG     = 1,
  parameter bit CTRL_REG     = 1
) (
  input  logic          clk,
  input  logic [AW-1:0] aRe,
  input  logic [AW-1:0] aIm,
  input  logic [AW-1:0] bRe,
  input  logic [AW-1:0] bIm,
  input  logic [AW-1:0] acinRe,
  input  logic [AW-1:0] acinIm,
  input  logic [AW-1:0] bcinRe,
  input  logic [AW-1:0] bcinIm,
  input  logic [PW-1:0] cRe,
  input  logic [PW-1:0] cIm,
  input  logic [PW-1:0] pcinRe,
  input  logic [PW-1:0] pcinIm,
  input  logic          conjA,
  input  logic          conjB,
  input  logic [1:0]    modeRe,
  input  logic [1:0]    modeIm,
  input  logic          ceA1,
  input  logic          ceA2,
  input  logic          ceB1,
  input  logic          ceB2,
  input  logic          ceC,
  input  logic          ceM,
  input  logic          ceP,
  input  logic          ceCtrl,
  input  logic          ceConj,
  input  logic          rstA,
  input  logic          rstB,
  input  logic          rstC,
  input  logic          rstM,
  input  logic          rstP,
  input  logic          rstCtrl,
  input  logic          rstConj,
  output logic [PW-1:0] pRe,
  output logic [PW-1:0] pIm,
  output logic [PW-1:0] pcoutRe,
  output logic [PW-1:0] pcoutIm,
  output logic [AW-1:0] acoutRe,
  output logic [AW-1:0] acoutIm,
  output logic [AW-1:0] bcoutRe,
  output logic [AW-1:0] bcoutIm
);
  ctrlStrobe_t strobe;
  logic [2*AW-1:0] acoutW, bcoutW;

  cmac_ctrl #(.CONJ_REG(CONJ_REG), .CTRL_REG(CTRL_REG)) uCtrl (
    .clk(clk), .conjA(conjA), .conjB(conjB), .modeRe(modeRe), .modeIm(modeIm),
    .ceConj(ceConj), .rstConj(rstConj), .ceCtrl(ceCtrl), .rstCtrl(rstCtrl),
    .strobe(strobe));

  cmac_datapath #(
    .AW(AW), .PW(PW), .A_DEPTH(A_DEPTH), .B_DEPTH(B_DEPTH),
    .ACOUT_TAP(ACOUT_TAP), .BCOUT_TAP(BCOUT_TAP),
    .A_IN_CASCADE(A_IN_CASCADE), .B_IN_CASCADE(B_IN_CASCADE),
    .C_REG(C_REG), .M_REG(M_REG), .P_REG(P_REG)
  ) uData (
    .clk(clk), .strobe(strobe),
    .aIn({aRe, aIm}), .acin({acinRe, acinIm}),
    .bIn({bRe, bIm}), .bcin({bcinRe, bcinIm}),
    .cRe(cRe), .cIm(cIm), .pcinRe(pcinRe), .pcinIm(pcinIm),
    .ceA({ceA2, ceA1}), .ceB({ceB2, ceB1}), .ceC(ceC), .ceM(ceM), .ceP(ceP),
    .rstA(rstA), .rstB(rstB), .rstC(rstC), .rstM(rstM), .rstP(rstP),
    .pRe(pRe), .pIm(pIm), .acout(acoutW), .bcout(bcoutW));

  assign pcoutRe = pRe;
  assign pcoutIm = pIm;
  assign {acoutRe, acoutIm} = acoutW;
  assign {bcoutRe, bcoutIm} = bcoutW;
endmodule

// File: tb/tb_cmac_unit.sv
module tb_cmac_unit;
  localparam int AW = 18;
  localparam int PW = 58;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] aRe, aIm, bRe, bIm;
  logic [PW-1:0] cRe, cIm, pcinRe, pcinIm;
  logic conjA, conjB;
  logic [1:0] modeRe, modeIm;
  logic ceA1, ceA2, ceB1, ceB2, ceC, ceM, ceP, ceCtrl, ceConj;
  logic rstA, rstB, rstC, rstM, rstP, rstCtrl, rstConj;
  logic [PW-1:0] pRe, pIm, pcoutRe, pcoutIm;
  logic [AW-1:0] acoutRe, acoutIm, bcoutRe, bcoutIm;
  logic [PW-1:0] p2Re, p2Im, pc2Re, pc2Im;
  logic [AW-1:0] ac2Re, ac2Im, bc2Re, bc2Im;

  cmac_unit dut (
    .clk(clk), .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .acinRe('0), .acinIm('0), .bcinRe('0), .bcinIm('0),
    .cRe(cRe), .cIm(cIm), .pcinRe(pcinRe), .pcinIm(pcinIm),
    .conjA(conjA), .conjB(conjB), .modeRe(modeRe), .modeIm(modeIm),
    .ceA1(ceA1), .ceA2(ceA2), .ceB1(ceB1), .ceB2(ceB2), .ceC(ceC), .ceM(ceM),
    .ceP(ceP), .ceCtrl(ceCtrl), .ceConj(ceConj),
    .rstA(rstA), .rstB(rstB), .rstC(rstC), .rstM(rstM), .rstP(rstP),
    .rstCtrl(rstCtrl), .rstConj(rstConj),
    .pRe(pRe), .pIm(pIm), .pcoutRe(pcoutRe), .pcoutIm(pcoutIm),
    .acoutRe(acoutRe), .acoutIm(acoutIm), .bcoutRe(bcoutRe), .bcoutIm(bcoutIm));

  cmac_unit #(.A_DEPTH(1), .B_DEPTH(0), .ACOUT_TAP(0), .BCOUT_TAP(0),
              .A_IN_CASCADE(1), .C_REG(0), .M_REG(0), .P_REG(0),
              .CONJ_REG(0), .CTRL_REG(0)) dut2 (
    .clk(clk), .aRe('0), .aIm('0), .bRe(bRe), .bIm(bIm),
    .acinRe(acoutRe), .acinIm(acoutIm), .bcinRe('0), .bcinIm('0),
    .cRe('0), .cIm('0), .pcinRe('0), .pcinIm('0),
    .conjA(conjA), .conjB(conjB), .modeRe(2'd0), .modeIm(2'd0),
    .ceA1(1'b1), .ceA2(1'b1), .ceB1(1'b1), .ceB2(1'b1), .ceC(1'b1), .ceM(1'b1),
    .ceP(1'b1), .ceCtrl(1'b1), .ceConj(1'b1),
    .rstA(1'b0), .rstB(1'b0), .rstC(1'b0), .rstM(1'b0), .rstP(1'b0),
    .rstCtrl(1'b0), .rstConj(1'b0),
    .pRe(p2Re), .pIm(p2Im), .pcoutRe(pc2Re), .pcoutIm(pc2Im),
    .acoutRe(ac2Re), .acoutIm(ac2Im), .bcoutRe(bc2Re), .bcoutIm(bc2Im));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [PW-1:0] refRe(longint ar, longint ai, longint br, longint bi,
                                          bit ca, bit cb);
    longint x;
    if (ca) ai = -ai;
    if (cb) bi = -bi;
    x = ar * br - ai * bi;
    return x[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] refIm(longint ar, longint ai, longint br, longint bi,
                                          bit ca, bit cb);
    longint x;
    if (ca) ai = -ai;
    if (cb) bi = -bi;
    x = ar * bi + ai * br;
    return x[PW-1:0];
  endfunction

  task automatic setAB(int ar, int ai, int br, int bi);
    aRe = AW'(ar); aIm = AW'(ai); bRe = AW'(br); bIm = AW'(bi);
  endtask

  initial begin
    int vals [6] = '{-131072, -1, 0, 1, 5, 131071};
    logic [PW-1:0] s0, s1;
    setAB(0, 0, 0, 0);
    cRe = '0; cIm = '0; pcinRe = '0; pcinIm = '0;
    conjA = 0; conjB = 0; modeRe = 2'd0; modeIm = 2'd0;
    {ceA1, ceA2, ceB1, ceB2, ceC, ceM, ceP, ceCtrl, ceConj} = '1;
    {rstA, rstB, rstC, rstM, rstP, rstCtrl, rstConj} = '1;
    setAB(9, 9, 9, 9);
    settle(3);
    // R8: reset state
    chk("R8 reset pRe", pRe, '0);
    chk("R8 reset pIm", pIm, '0);
    chk("R8 reset acout", PW'(acoutRe), '0);
    {rstA, rstB, rstC, rstM, rstP, rstCtrl, rstConj} = '0;

    // R1/R2/R6/R9: sweep of corner operands under every conjugate setting
    for (int c = 0; c < 4; c++) begin
      for (int i0 = 0; i0 < 6; i0++)
        for (int i1 = 0; i1 < 6; i1++)
          for (int i2 = 0; i2 < 6; i2++)
            for (int i3 = 0; i3 < 6; i3++) begin
              conjA = c[1]; conjB = c[0];
              setAB(vals[i0], vals[i1], vals[i2], vals[i3]);
              settle(5);
              chk("R1 R2 real", pRe, refRe(vals[i0], vals[i1], vals[i2], vals[i3], c[1], c[0]));
              chk("R1 R2 imag", pIm, refIm(vals[i0], vals[i1], vals[i2], vals[i3], c[1], c[0]));
              chk("R6 cascade A real", p2Re, refRe(vals[i0], vals[i1], vals[i2], vals[i3], c[1], c[0]));
              chk("R6 cascade A imag", p2Im, refIm(vals[i0], vals[i1], vals[i2], vals[i3], c[1], c[0]));
              if (i3 == 5) begin
                chk("R9 pcout real", pcoutRe, pRe);
                chk("R9 pcout imag", pcoutIm, pIm);
              end
            end
    end
    conjA = 0; conjB = 0;

    // R4 and R5: latency and cascade tap timing
    setAB(2, 0, 7, 0);
    settle(6);
    chk("R4 base", pRe, 58'd14);
    setAB(5, 0, 11, 0);
    settle(1);
    chk("R5 bcout tap 1", PW'(bcoutRe), 58'd11);
    chk("R5 acout before tap", PW'(acoutRe), 58'd2);
    settle(1);
    chk("R5 acout at tap 2", PW'(acoutRe), 58'd5);
    settle(1);
    chk("R4 unchanged after 3 edges", pRe, 58'd14);
    settle(1);
    chk("R4 updated after 4 edges", pRe, 58'd55);

    // R3: add C, add cascade, accumulate
    setAB(3, 2, 4, 1);  // re = 10, im = 11
    cRe = 58'd1000; cIm = 58'd2000;
    modeRe = 2'd2; modeIm = 2'd2;
    settle(6);
    chk("R3 add C real", pRe, 58'd1010);
    chk("R3 add C imag", pIm, 58'd2011);
    pcinRe = 58'd100000; pcinIm = -58'd5;
    modeRe = 2'd3; modeIm = 2'd3;
    settle(6);
    chk("R3 add cascade real", pRe, 58'd100010);
    chk("R3 add cascade imag", pIm, 58'd6);
    modeRe = 2'd1; modeIm = 2'd1;
    settle(6);
    s0 = pRe;
    settle(1);
    s1 = pRe;
    chk("R3 accumulate real step", s1 - s0, 58'd10);
    s0 = pIm;
    settle(1);
    chk("R3 accumulate imag step", pIm - s0, 58'd11);

    // R8: group resets clear only their group
    modeRe = 2'd2; modeIm = 2'd2;
    rstC = 1;
    settle(6);
    chk("R8 C cleared, product intact", pRe, 58'd10);
    rstP = 1;
    settle(2);
    chk("R8 P cleared", pRe, '0);
    chk("R8 A chain untouched by P reset", PW'(acoutRe), 58'd3);
    rstP = 0; rstC = 0;
    modeRe = 2'd0; modeIm = 2'd0;
    settle(6);
    chk("R8 recovered", pRe, 58'd10);

    // R7: clock enables hold their stage
    ceP = 0;
    setAB(6, 0, 6, 0);
    settle(6);
    chk("R7 P held", pRe, 58'd10);
    ceP = 1;
    settle(2);
    chk("R7 P released", pRe, 58'd36);
    ceA1 = 0;
    setAB(7, 0, 6, 0);
    settle(6);
    chk("R7 A stage 1 held", pRe, 58'd36);
    ceA1 = 1;
    settle(6);
    chk("R7 A stage 1 released", pRe, 58'd42);
    ceB2 = 0;
    setAB(7, 0, 2, 0);
    settle(6);
    chk("R7 B stage 2 held", pRe, 58'd42);
    ceB2 = 1;
    settle(6);
    chk("R7 B stage 2 released", pRe, 58'd14);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule